// File: doc/BRIEF.md
# Programmable-Priority Memory Arbiter

This block decides which of four requesters may use a single shared external memory port. The requesters are a processor (index 0), a DMA engine (index 1), an image buffer (index 2) and a DSP host port (index 3). Each one raises its bit of `req` while it wants the port. The arbiter answers with a registered one-hot `grant` vector.

Every requester has its own 2-bit priority level, which software can rewrite at run time through a small configuration write port. Among the pending requesters, the one with the numerically smallest level wins. When levels are equal, the lower index wins.

A grant covers a whole transaction. Once a grant is given it is never taken away, whatever other requests or level changes arrive. It ends only when the owner pulses its `done` bit. The cycle after that the port is idle, and on the following edge a fresh arbitration takes place. The block moves no data: it only produces the grant.

Top module: `prio_mem_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first sampling after it rises, `grant` is 0. Reset loads the levels as processor 0, DMA 1, image buffer 2, DSP 3.
- R2: `grant` is always either all zero or has exactly one bit set. Bit i set means requester i owns the port.
- R3: When `grant` is 0 and at least one `req` bit is high at a rising edge, `grant` shows the winner right after that edge.
- R4: The winner is the pending requester whose level has the smallest value, where 0 is the highest priority and 3 the lowest. Among equal levels, the lowest index wins.
- R5: A rising edge with `cfg_we` high stores `cfg_lvl` as the level of requester `cfg_id`. The new level is used only by arbitrations at later edges, never at the edge of the write itself.
- R6: While `grant` is nonzero and the owner's `done` bit is low, `grant` keeps its value. This holds even if other requests, level writes, or the owner dropping its own `req` occur.
- R7: `done` bits of requesters that do not own the port have no effect.
- R8: An edge where the owner's `done` bit is high clears `grant` to 0. Arbitration resumes at the next edge.
- R9: A newly set grant bit always belongs to a requester whose `req` was high at the arbitrating edge. With no request pending, `grant` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Request per requester (bit 0 processor, 1 DMA, 2 image buffer, 3 DSP) |
| done | input | 4 | Transaction-finished pulse per requester |
| cfg_we | input | 1 | Level write strobe |
| cfg_id | input | 2 | Requester index whose level is written |
| cfg_lvl | input | 2 | New level value, 0 highest to 3 lowest |
| grant | output | 4 | Registered one-hot grant, zero when idle |

## Verification
Every result of this block comes one register stage after its cause. A grant appears right after the edge that sampled `req` while the port was idle. A `done` from the owner clears `grant` after its edge, and the next owner appears one edge later. A level write affects only arbitrations at later edges. The bench changes inputs just after a falling edge and reads `grant` at the following falling edge, so each check sees the state after exactly one rising edge. The hold and release checks advance one edge at a time and sample after each one.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_NUM_REQ = 4;
  localparam int unsigned ARB_LVL_W   = 2;

  // True when level a strictly outranks level b (smaller value wins).
  function automatic logic lvl_beats(input logic [ARB_LVL_W-1:0] a,
                                     input logic [ARB_LVL_W-1:0] b);
    return a < b;
  endfunction

  // Level loaded at reset: the requester index, wrapped to the level range.
  function automatic logic [ARB_LVL_W-1:0] reset_level(input int unsigned idx);
    return ARB_LVL_W'(idx % (1 << ARB_LVL_W));
  endfunction
endpackage

// File: rtl/arb_level_regs.sv
module arb_level_regs
  import arb_pkg::*;
#(
  parameter int unsigned NUM_REQ = ARB_NUM_REQ,
  parameter int unsigned LVL_W   = ARB_LVL_W,
  localparam int unsigned ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [LVL_W-1:0] wr_lvl,
  output logic [LVL_W-1:0] lvl [NUM_REQ]
);
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_lvl
    logic hit;
    assign hit = wr_en && (wr_id == ID_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl[i] <= LVL_W'(reset_level(i));
      else if (hit) lvl[i] <= wr_lvl;
    end
  end
endmodule

// File: rtl/arb_winner_pick.sv
module arb_winner_pick
  import arb_pkg::*;
#(
  parameter int unsigned NUM_REQ = ARB_NUM_REQ,
  parameter int unsigned LVL_W   = ARB_LVL_W
) (
  input  logic [NUM_REQ-1:0] req,
  input  logic [LVL_W-1:0]   lvl [NUM_REQ],
  output logic [NUM_REQ-1:0] pick,
  output logic               any
);
  logic [LVL_W-1:0] best;

  // Ascending scan with strict comparison: ties stay with the lower index.
  always_comb begin
    pick = '0;
    any  = 1'b0;
    best = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req[i] && (!any || lvl_beats(LVL_W'(lvl[i]), LVL_W'(best)))) begin
        pick    = '0;
        pick[i] = 1'b1;
        best    = lvl[i];
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl #(
  parameter int unsigned NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] pick,
  input  logic               any,
  input  logic [NUM_REQ-1:0] done,
  output logic [NUM_REQ-1:0] grant,
  output logic               busy,
  output logic               release_ev,
  output logic               arb_ev
);
  assign busy       = |grant;
  assign release_ev = |(grant & done);   // only the owner's done counts
  assign arb_ev     = !busy && any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          grant <= '0;
    else if (release_ev) grant <= '0;
    else if (arb_ev)     grant <= pick;
  end
endmodule

// File: rtl/prio_mem_arbiter.sv
module prio_mem_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_REQ = ARB_NUM_REQ,
  parameter int unsigned LVL_W   = ARB_LVL_W,
  localparam int unsigned ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic [NUM_REQ-1:0] done,
  input  logic               cfg_we,
  input  logic [ID_W-1:0]    cfg_id,
  input  logic [LVL_W-1:0]   cfg_lvl,
  output logic [NUM_REQ-1:0] grant
);
  logic [LVL_W-1:0]   lvl [NUM_REQ];
  logic [NUM_REQ-1:0] pick_vec;
  logic               pick_any;
  logic               port_busy;
  logic               release_ev;
  logic               arb_ev;

  arb_level_regs #(.NUM_REQ(NUM_REQ), .LVL_W(LVL_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_id(cfg_id),
    .wr_lvl(cfg_lvl), .lvl(lvl)
  );

  arb_winner_pick #(.NUM_REQ(NUM_REQ), .LVL_W(LVL_W)) u_pick (
    .req(req), .lvl(lvl), .pick(pick_vec), .any(pick_any)
  );

  arb_grant_ctrl #(.NUM_REQ(NUM_REQ)) u_gnt (
    .clk(clk), .rst_n(rst_n), .pick(pick_vec), .any(pick_any), .done(done),
    .grant(grant), .busy(port_busy), .release_ev(release_ev), .arb_ev(arb_ev)
  );
endmodule

// File: rtl/prio_mem_arbiter_chk.sv
module prio_mem_arbiter_chk #(
  parameter int unsigned NUM_REQ = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] req,
  input logic [NUM_REQ-1:0] done,
  input logic [NUM_REQ-1:0] grant,
  input logic               release_ev,
  input logic               arb_ev
);
  // R1: an edge inside reset leaves the port ungranted
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> grant == '0);

  // R2: one owner at most
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3: idle port with a pending request is granted after one edge
  a_r3_grant_next: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req != '0) |=> grant != '0);

  // R6, R7: no owner change without the owner's done
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (grant & done) == '0) |=> $stable(grant));

  // R8: owner's done frees the port for one cycle
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> grant == '0);

  // R9: a new grant goes to a requester that asked
  a_r9_req_owner: assert property (@(posedge clk) disable iff (!rst_n)
    arb_ev |=> (grant & $past(req)) != '0);

  // R9: nothing pending on an idle port keeps it idle
  a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req == '0) |=> grant == '0);
endmodule

bind prio_mem_arbiter prio_mem_arbiter_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .done(done), .grant(grant),
  .release_ev(release_ev), .arb_ev(arb_ev)
);

// File: tb/sim_prio_mem_arbiter.sv
module sim_prio_mem_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] done = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_id = '0;
  logic [1:0] cfg_lvl = '0;
  logic [3:0] grant;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  prio_mem_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .cfg_we(cfg_we),
    .cfg_id(cfg_id), .cfg_lvl(cfg_lvl), .grant(grant)
  );

  // Each vector: {levels l3,l2,l1,l0 (2 bits each), req, expected grant}
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    {8'b11_10_01_00, 4'b1111, 4'b0001},
    {8'b11_10_01_00, 4'b1110, 4'b0010},
    {8'b11_10_01_00, 4'b1100, 4'b0100},
    {8'b11_10_01_00, 4'b1000, 4'b1000},
    {8'b00_01_10_11, 4'b1111, 4'b1000},
    {8'b00_00_00_00, 4'b1111, 4'b0001},
    {8'b10_10_10_10, 4'b1010, 4'b0010},
    {8'b10_01_01_11, 4'b1101, 4'b0100},
    {8'b10_01_01_11, 4'b0110, 4'b0010},
    {8'b11_11_11_00, 4'b1110, 4'b0010},
    {8'b11_10_01_00, 4'b0000, 4'b0000}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] exp);
    checks++;
    if (grant !== exp) begin
      errors++;
      $display("FAIL %s grant=%b expected=%b", tag, grant, exp);
    end
  endtask

  task automatic set_lvl(input logic [1:0] id, input logic [1:0] lv);
    cfg_we = 1'b1; cfg_id = id; cfg_lvl = lv;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic finish_txn();
    done = grant;
    tick();
    done = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick();
    check("R1 grant in reset", 4'b0000);
    req = 4'b1111;
    tick();
    check("R1 grant ignores req in reset", 4'b0000);
    req = '0;
    rst_n = 1'b1;
    tick();
    check("R1 grant after reset", 4'b0000);

    // R1 defaults: DMA (1) beats DSP (3)
    req = 4'b1010;
    tick();
    check("R1 default levels DMA over DSP", 4'b0010);
    req = '0;
    finish_txn();
    check("R8 cleared after done", 4'b0000);

    // Table walk (R3, R4, R5, R9)
    for (int v = 0; v < NV; v++) begin
      for (int r = 0; r < 4; r++) set_lvl(2'(r), VEC[v][8 + 2*r +: 2]);
      req = VEC[v][7:4];
      tick();
      check($sformatf("R4 vector %0d", v), VEC[v][3:0]);
      req = '0;
      if (grant != '0) begin
        finish_txn();
        check($sformatf("R8 vector %0d release", v), 4'b0000);
      end
    end
    check("R9 no request stays idle", 4'b0000);

    // R5: write at the arbitrating edge is not yet used
    for (int r = 0; r < 4; r++) set_lvl(2'(r), 2'(r));
    req = 4'b0011; cfg_we = 1'b1; cfg_id = 2'd0; cfg_lvl = 2'd3;
    tick();
    cfg_we = 1'b0;
    check("R5 same-edge write uses old level", 4'b0001);
    finish_txn();
    check("R8 idle cycle after done", 4'b0000);
    tick();
    check("R5 new level used next arbitration", 4'b0010);
    req = '0;
    finish_txn();

    // R6 / R7: hold against competition, level changes, foreign done
    for (int r = 0; r < 4; r++) set_lvl(2'(r), 2'(r));
    req = 4'b1000;
    tick();
    check("R3 DSP granted alone", 4'b1000);
    req = 4'b1111;
    set_lvl(2'd0, 2'd0);
    check("R6 held against higher request", 4'b1000);
    set_lvl(2'd3, 2'd3);
    check("R6 held after owner level write", 4'b1000);
    req = 4'b0111;
    tick();
    check("R6 held after owner drops req", 4'b1000);
    done = 4'b0111;
    tick();
    check("R7 foreign done ignored", 4'b1000);
    tick();
    check("R7 foreign done ignored again", 4'b1000);
    done = 4'b1000;
    tick();
    done = '0;
    check("R8 owner done clears", 4'b0000);
    tick();
    check("R8 rearbitration to processor", 4'b0001);
    req = 4'b0110;
    finish_txn();
    check("R8 cleared", 4'b0000);
    tick();
    check("R4 DMA next after processor", 4'b0010);
    req = '0;
    finish_txn();
    tick();
    check("R9 idle with nothing pending", 4'b0000);

    // R1 mid-run reset drops a held grant
    req = 4'b0100;
    tick();
    check("R3 image buffer granted", 4'b0100);
    rst_n = 1'b0;
    tick();
    check("R1 reset drops grant", 4'b0000);
    rst_n = 1'b1;
    req = '0;
    tick();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule